// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block is a master-only controller for a two-wire I2C bus. Software, or a small sequencer, drives it one command at a time. There are four commands: open a transfer, write one byte, read one byte, and close the transfer. Opening a transfer generates a START condition and sends the control byte. That byte holds a 4-bit device-type address, a 3-bit strap address and a direction bit. The block then samples the slave's acknowledge on the ninth clock. Between bytes it holds SCL low, so the bus waits for the next command.

Both bus lines are open-drain. The block never drives a line high. It asserts a drive-low enable for each line and reads the resolved level back on a separate input. Three sticky flags report status. `ack` holds the last acknowledge received. `nak` records an address byte that no device answered. `berr` records line activity the master did not request, which shows that another master is driving the bus. The block never acts as a slave.

SCL timing is fixed by one parameter: the number of system clocks in each half of the SCL period. The default of 66 gives 132 clocks per bit. With a 12 MHz system clock that is about 90.9 kHz.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `busy`, `done`, `ack`, `nak` and `berr` are all 0, and `rd_data` is 0.
- R2: A START command (`cmd_op` = 0) accepted while idle first pulls SDA low while SCL stays released, for HALF_CLKS clocks. Only then does SCL go low. Apart from that START and the closing STOP, `sda_oe` changes only while SCL is driven low.
- R3: Address and write bytes are shifted out most significant bit first. In the control byte, bits 7:4 are the device type and bits 3:1 are the strap address. Bit 0 is the direction: 1 means the master reads and 0 means it writes.
- R4: After the eight bits of an address byte or a write byte (`cmd_op` = 1), the master releases SDA for a ninth SCL pulse. It samples SDA in the last clock of that pulse's high half. It sets `ack` to 1 if SDA was low and to 0 if SDA was high.
- R5: If the address byte is not acknowledged, the block sets `nak` and issues STOP by itself. It then returns to idle without clocking any data byte. The next START clears `nak`.
- R6: During a read (`cmd_op` = 2), the master releases SDA for all eight data bits. It shifts the bits in most significant first and presents the byte on `rd_data` when the read finishes.
- R7: On the ninth clock of a read, the master drives SDA low (ACK) when `cmd_last` was 0. When `cmd_last` was 1 it leaves SDA released (NAK).
- R8: A STOP command (`cmd_op` = 3) issued while the bus is held proceeds in three steps. SDA is driven low while SCL is low. SCL is then released. Finally SDA is released while SCL is high, which leaves both lines released and the block idle.
- R9: `berr` is set in either of two cases. The first is SDA read low at the sample point of a transmitted data bit that the master is leaving released. The second is SCL read low at the sample point while the master releases it. The ACK slot never sets `berr`. The flag stays set until a one-cycle pulse on `berr_clr` clears it.
- R10: Every bit spends exactly HALF_CLKS clocks with SCL low, followed by exactly HALF_CLKS clocks with SCL released.
- R11: The block ignores the following commands, with no change on the bus and `busy` staying 0:
  - any command other than START while idle;
  - START while the bus is held between bytes.
- R12: `busy` is 1 while a command executes. `done` goes to 1 when the command finishes, and goes back to 0 when the next command is accepted. Between bytes the master keeps SCL driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | Command: 0 start+address, 1 write, 2 read, 3 stop |
| cmd_byte | input | 8 | Control byte for start, data byte for write |
| cmd_last | input | 1 | For reads: final byte, answer with NAK |
| berr_clr | input | 1 | Clears the bus-error flag |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | A command is executing |
| done | output | 1 | Last accepted command has finished |
| ack | output | 1 | Acknowledge seen on the last transmitted byte |
| nak | output | 1 | Address byte went unanswered |
| berr | output | 1 | Foreign drive detected on the bus |
| rd_data | output | 8 | Last byte read from the slave |

## Verification
The bench builds the block with HALF_CLKS = 4, so one bit takes eight clocks instead of 132. This lets a few dozen complete transfers of up to three bytes run in either direction within the cycle budget. Those transfers cover address rejection, master NAK on the last read byte, and a bus-error episode. Because the half-period is short, the exact low and high widths of SCL can be measured edge to edge. Behaviour at the default of 66 follows from the same timer compare and is checked only by elaboration.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_BIT   = 3'd2,
        S_HOLD  = 3'd3,
        S_STOP1 = 3'd4,
        S_STOP2 = 3'd5
    } st_e;

    typedef struct packed {
        st_e        st;
        logic [3:0] bitn;
        logic [7:0] sh;
        logic       rx;
        logic       last;
        logic       addr;
        logic       done;
        logic [7:0] rdata;
    } ctl_t;

    typedef struct packed {
        logic ack;
        logic nak;
        logic berr;
    } flags_t;

endpackage

// File: rtl/i2cm_bit_timer.sv
module i2cm_bit_timer #(
    parameter int HALF_CLKS = 66
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic hi,
    output logic half_end,
    output logic per_end
);
    localparam int PERIOD = 2 * HALF_CLKS;
    localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] HALF_C = CW'(HALF_CLKS);
    localparam logic [CW-1:0] HLAST  = CW'(HALF_CLKS - 1);
    localparam logic [CW-1:0] PLAST  = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        hi       = (cnt_q >= HALF_C);
        half_end = (cnt_q == HLAST);
        per_end  = (cnt_q == PLAST);
        if (clr || per_end) cnt_d = '0;
        else                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Period wraps to the start of the low half (R10)
    p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (per_end && !clr) |=> (cnt_q == '0))
        else $error("period did not wrap");

    // After the low half ends, the high half follows (R10)
    p_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (half_end && !clr) |=> hi)
        else $error("high half did not follow low half");

endmodule

// File: rtl/i2cm_flags.sv
module i2cm_flags
    import i2cm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ack_we,
    input  logic   ack_val,
    input  logic   nak_set,
    input  logic   nak_clr,
    input  logic   berr_set,
    input  logic   berr_clr,
    output flags_t flags_q
);
    flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (ack_we)   flags_d.ack  = ack_val;
        if (nak_clr)  flags_d.nak  = 1'b0;
        if (nak_set)  flags_d.nak  = 1'b1;
        if (berr_clr) flags_d.berr = 1'b0;
        if (berr_set) flags_d.berr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // The bus-error flag falls only on a software clear (R9)
    p_berr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags_q.berr) |-> $past(berr_clr))
        else $error("berr dropped without clear");

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int HALF_CLKS = 66
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic [7:0] cmd_byte,
    input  logic       cmd_last,
    input  logic       berr_clr,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       done,
    output logic       ack,
    output logic       nak,
    output logic       berr,
    output logic [7:0] rd_data
);
    localparam logic [3:0] ACK_SLOT = 4'd8;

    ctl_t   q, d;
    flags_t fl;
    op_e    op;
    logic   t_clr, t_hi, t_half_end, t_end;
    logic   ack_we, ack_val, nak_set, nak_clr, berr_set;
    logic   tx_rel;

    assign op = op_e'(cmd_op);

    i2cm_bit_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (t_clr),
        .hi       (t_hi),
        .half_end (t_half_end),
        .per_end  (t_end)
    );

    i2cm_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_we   (ack_we),
        .ack_val  (ack_val),
        .nak_set  (nak_set),
        .nak_clr  (nak_clr),
        .berr_set (berr_set),
        .berr_clr (berr_clr),
        .flags_q  (fl)
    );

    always_comb begin
        d        = q;
        t_clr    = 1'b0;
        ack_we   = 1'b0;
        ack_val  = 1'b0;
        nak_set  = 1'b0;
        nak_clr  = 1'b0;
        berr_set = 1'b0;
        scl_oe   = 1'b0;
        sda_oe   = 1'b0;
        tx_rel   = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (cmd_valid && op == OP_START) begin
                    d.st   = S_START;
                    d.sh   = cmd_byte;
                    d.rx   = 1'b0;
                    d.addr = 1'b1;
                    d.last = 1'b0;
                    d.done = 1'b0;
                    t_clr  = 1'b1;
                    nak_clr = 1'b1;
                end
            end
            S_START: begin
                sda_oe = 1'b1;
                if (t_half_end) begin
                    d.st   = S_BIT;
                    d.bitn = '0;
                    t_clr  = 1'b1;
                end
            end
            S_BIT: begin
                scl_oe = !t_hi;
                if (q.bitn < ACK_SLOT) begin
                    sda_oe = !q.rx && !q.sh[7];
                    tx_rel = !q.rx && q.sh[7];
                end else begin
                    sda_oe = q.rx && !q.last;
                end
                if (t_end) begin
                    if ((tx_rel && !sda_in) || !scl_in) berr_set = 1'b1;
                    if (q.bitn < ACK_SLOT) begin
                        d.sh   = {q.sh[6:0], sda_in};
                        d.bitn = q.bitn + 4'd1;
                    end else begin
                        d.bitn = '0;
                        if (q.rx) begin
                            d.rdata = q.sh;
                            d.st    = S_HOLD;
                            d.done  = 1'b1;
                        end else begin
                            ack_we  = 1'b1;
                            ack_val = !sda_in;
                            if (q.addr && sda_in) begin
                                nak_set = 1'b1;
                                d.st    = S_STOP1;
                                t_clr   = 1'b1;
                            end else begin
                                d.st   = S_HOLD;
                                d.done = 1'b1;
                            end
                        end
                    end
                end
            end
            S_HOLD: begin
                scl_oe = 1'b1;
                if (cmd_valid) begin
                    case (op)
                        OP_WRITE: begin
                            d.st   = S_BIT;
                            d.sh   = cmd_byte;
                            d.rx   = 1'b0;
                            d.addr = 1'b0;
                            d.bitn = '0;
                            d.done = 1'b0;
                            t_clr  = 1'b1;
                        end
                        OP_READ: begin
                            d.st   = S_BIT;
                            d.sh   = '0;
                            d.rx   = 1'b1;
                            d.last = cmd_last;
                            d.addr = 1'b0;
                            d.bitn = '0;
                            d.done = 1'b0;
                            t_clr  = 1'b1;
                        end
                        OP_STOP: begin
                            d.st   = S_STOP1;
                            d.done = 1'b0;
                            t_clr  = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            S_STOP1: begin
                scl_oe = !t_hi;
                sda_oe = 1'b1;
                if (t_end) begin
                    d.st  = S_STOP2;
                    t_clr = 1'b1;
                end
            end
            S_STOP2: begin
                if (t_half_end) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = (q.st != S_IDLE) && (q.st != S_HOLD);
    assign done    = q.done;
    assign ack     = fl.ack;
    assign nak     = fl.nak;
    assign berr    = fl.berr;
    assign rd_data = q.rdata;

    // With SCL released, SDA moves only to form START or STOP (R2, R8)
    p_sda_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
        |-> ((sda_oe && $past(q.st) == S_IDLE) || (!sda_oe && $past(q.st) == S_STOP1)))
        else $error("SDA moved while SCL high");

    // The ack flag is written only at the end of the ninth clock (R4)
    p_ack_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fl.ack != $past(fl.ack)) |-> $past(q.st == S_BIT && q.bitn == ACK_SLOT && t_end))
        else $error("ack changed outside ninth clock");

    // A rejected address leads straight into STOP (R5)
    p_nak_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl.nak) |-> (q.st == S_STOP1))
        else $error("nak without stop");

    // Bus errors are only detected at a bit sample point (R9)
    p_berr_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl.berr) |-> $past(q.st == S_BIT && t_end))
        else $error("berr raised outside a bit");

    // Non-start commands do nothing while idle (R11)
    p_idle_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && cmd_valid && op != OP_START) |=> (q.st == S_IDLE))
        else $error("idle accepted a non-start command");

    // Accepting a command clears done (R12)
    p_busy_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done)
        else $error("done still set at command start");

endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
    import i2cm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_byte = 8'd0;
    logic       cmd_last = 1'b0;
    logic       berr_clr = 1'b0;
    logic       scl_in, sda_in;
    logic       scl_oe, sda_oe, busy, done, ack, nak, berr;
    logic [7:0] rd_data;

    logic sv_drive = 1'b0;
    logic bully = 1'b0;
    logic scl_line, sda_line;
    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || sv_drive || bully);
    assign scl_in   = scl_line;
    assign sda_in   = sda_line;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_byte_master #(.HALF_CLKS(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .cmd_last(cmd_last), .berr_clr(berr_clr),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .done(done), .ack(ack), .nak(nak), .berr(berr),
        .rd_data(rd_data)
    );

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Slave model and bus monitor
    logic       addr_ack = 1'b1;
    logic [7:0] rd_bytes [4];
    logic [7:0] got_wr [4];
    logic       mack [4];
    logic [7:0] got_addr, sv_sh;
    logic       sv_active, sv_rd, p_scl, p_sda;
    int sv_bit, sv_idx, sv_bytes, start_cnt, stop_cnt;
    int t_rise, t_fall, hi_len, lo_len;

    always @(negedge clk) begin
        if (!rst_n) begin
            sv_active = 1'b0; sv_drive = 1'b0; sv_rd = 1'b0; sv_sh = '0;
            start_cnt = 0; stop_cnt = 0; sv_bytes = 0; sv_bit = 0; sv_idx = 0;
            p_scl = 1'b1; p_sda = 1'b1; got_addr = '0;
            t_rise = 0; t_fall = 0; hi_len = 0; lo_len = 0;
        end else begin
            if (scl_line && p_scl && p_sda && !sda_line) begin
                start_cnt++; sv_active = 1'b1; sv_bit = -1; sv_idx = 0;
                sv_bytes = 0; sv_drive = 1'b0;
            end else if (scl_line && p_scl && !p_sda && sda_line) begin
                stop_cnt++; sv_active = 1'b0; sv_drive = 1'b0;
            end else if (scl_line && !p_scl) begin
                if (sv_active && sv_bit >= 1 && sv_bit <= 7) lo_len = cyc - t_fall;
                t_rise = cyc;
                if (sv_active) begin
                    if (sv_bit < 8) sv_sh = {sv_sh[6:0], sda_line};
                    else begin
                        sv_bytes++;
                        if (sv_idx == 0) begin
                            got_addr = sv_sh; sv_rd = sv_sh[0];
                            if (!addr_ack) sv_active = 1'b0;
                        end else if (sv_idx <= 4) begin
                            if (!sv_rd) got_wr[sv_idx-1] = sv_sh;
                            else begin
                                mack[sv_idx-1] = !sda_line;
                                if (sda_line) sv_active = 1'b0;
                            end
                        end
                    end
                end
            end else if (!scl_line && p_scl) begin
                if (sv_active && sv_bit >= 1 && sv_bit <= 7) hi_len = cyc - t_rise;
                t_fall = cyc;
                sv_drive = 1'b0;
                if (sv_active) begin
                    if (sv_bit == 8) begin sv_bit = 0; sv_idx++; end
                    else sv_bit++;
                    if (sv_bit == 8 && (sv_idx == 0 || !sv_rd))
                        sv_drive = (sv_idx == 0) ? addr_ack : 1'b1;
                    else if (sv_idx > 0 && sv_idx <= 4 && sv_rd && sv_bit < 8)
                        sv_drive = !rd_bytes[sv_idx-1][7-sv_bit];
                end
            end
            p_scl = scl_line;
            p_sda = sda_line;
        end
    end

    function automatic logic [7:0] make_ctrl(input logic [3:0] ty, input logic [2:0] sa,
                                             input logic dir);
        return {ty, sa, dir};
    endfunction

    function automatic int exp_mack(input int i, input int n);
        return (i != n - 1) ? 1 : 0;
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input op_e op, input logic [7:0] b, input logic lst);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_byte = b; cmd_last = lst;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    logic [7:0] tx_bytes [4];

    task automatic run_xfer(input logic [3:0] ty, input logic [2:0] sa, input logic dir,
                            input int n, input logic ackit);
        int s0;
        int p0;
        s0 = start_cnt;
        p0 = stop_cnt;
        addr_ack = ackit;
        issue(OP_START, make_ctrl(ty, sa, dir), 1'b0);
        check_eq("R3 control byte", got_addr, make_ctrl(ty, sa, dir));
        check_eq("R2 start seen", start_cnt, s0 + 1);
        check_eq("R4 address ack flag", ack, ackit);
        check_eq("R5 nak flag", nak, !ackit);
        if (!ackit) begin
            check_eq("R5 auto stop", stop_cnt, p0 + 1);
            check_eq("R5 no data clocked", sv_bytes, 1);
            check_eq("R5 idle released", {busy, scl_oe, sda_oe}, 0);
            check_eq("R12 done after nak", done, 1);
            return;
        end
        check_eq("R12 held between bytes", {scl_oe, done}, 3);
        for (int i = 0; i < n; i++) begin
            if (!dir) begin
                issue(OP_WRITE, tx_bytes[i], 1'b0);
                check_eq("R3 write byte", got_wr[i], tx_bytes[i]);
                check_eq("R4 data ack flag", ack, 1);
            end else begin
                issue(OP_READ, 8'h00, (i == n - 1));
                check_eq("R6 read byte", rd_data, rd_bytes[i]);
                check_eq("R7 master ack", mack[i], exp_mack(i, n));
            end
            check_eq("R12 done after byte", done, 1);
        end
        issue(OP_STOP, 8'h00, 1'b0);
        check_eq("R8 stop seen", stop_cnt, p0 + 1);
        check_eq("R8 released idle", {busy, scl_oe, sda_oe}, 0);
        check_eq("R9 no error on clean transfer", berr, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        int sd;
        int s0;
        sd = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 reset outputs", {scl_oe, sda_oe, busy, done, ack, nak, berr}, 0);
        check_eq("R1 reset rd_data", rd_data, 0);

        // Directed write with boundary bytes
        tx_bytes[0] = 8'h00; tx_bytes[1] = 8'hFF; tx_bytes[2] = 8'hA5;
        run_xfer(4'b1010, 3'b011, 1'b0, 3, 1'b1);
        check_eq("R10 scl low half", lo_len, HALF);
        check_eq("R10 scl high half", hi_len, HALF);

        // Directed read
        rd_bytes[0] = 8'h3C; rd_bytes[1] = 8'hC3;
        run_xfer(4'b0101, 3'b100, 1'b1, 2, 1'b1);

        // Address rejected
        run_xfer(4'b1111, 3'b111, 1'b0, 2, 1'b0);

        // R11: write while idle ignored
        s0 = start_cnt;
        issue(OP_WRITE, 8'h55, 1'b0);
        repeat (3 * HALF) @(negedge clk);
        check_eq("R11 idle ignores write", {busy, scl_oe, sda_oe}, 0);
        check_eq("R11 no start from write", start_cnt, s0);

        // R11: start while held ignored
        addr_ack = 1'b1;
        issue(OP_START, make_ctrl(4'b0011, 3'b001, 1'b0), 1'b0);
        issue(OP_START, 8'hFF, 1'b0);
        repeat (3 * HALF) @(negedge clk);
        check_eq("R11 held ignores start", {busy, scl_oe, done}, 3);
        check_eq("R11 no second start", start_cnt, s0 + 1);

        // R9: foreign drive during a released data bit
        bully = 1'b1;
        issue(OP_WRITE, 8'hFF, 1'b0);
        bully = 1'b0;
        check_eq("R9 berr set", berr, 1);
        issue(OP_STOP, 8'h00, 1'b0);
        check_eq("R9 berr sticky", berr, 1);
        @(negedge clk); berr_clr = 1'b1;
        @(negedge clk); berr_clr = 1'b0;
        check_eq("R9 berr cleared", berr, 0);

        // Random transfers
        for (int k = 0; k < 40; k++) begin
            logic [3:0] ty;
            logic [2:0] sa;
            logic       dir;
            logic       ackit;
            int         n;
            ty    = 4'($urandom);
            sa    = 3'($urandom);
            dir   = 1'($urandom);
            n     = 1 + int'($urandom % 3);
            ackit = (($urandom % 6) != 0);
            for (int i = 0; i < 4; i++) begin
                tx_bytes[i] = 8'($urandom);
                rd_bytes[i] = 8'($urandom);
            end
            run_xfer(ty, sa, dir, n, ackit);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

endmodule